// File: doc/BRIEF.md
# Power-Management Serial Control Register Bank

This block is the serial control front end of a small battery power-management controller. A host talks to it over a four-wire SPI-style link (active-low chip select, serial clock, data in, tri-stated data out) with 8-bit command bytes sent most significant bit first. A command byte whose top bit is clear carries a 2-bit register address in bits 6:5 and a 5-bit payload in bits 4:0. A command byte whose top bit is set carries a 7-bit comparator threshold code in bits 6:0. During every transfer the block returns a status byte: three comparator results and a low-battery flag.

From the stored registers the block drives the decoded control lines of the supply. These are the converter enable and run/coast selection, two linear-regulator enables, two open-drain driver enables, the two charge-current selections, the backup-regulator enable, the 5-bit output-voltage code and the threshold code. Some of these lines combine register bits with live inputs. The second driver is gated by an external audio-rate input. The backup regulator can be started automatically by the low-battery flag, and an active backup shuts off the converter and the charger. A reset-detector input puts every register back to its power-on value.

The serial lines are sampled by the block's own system clock through synchronizer stages. The serial clock must therefore be slower than the system clock: each level of the serial clock has to be held for at least SYNC_STAGES + 2 system clock cycles.

Top module: `pm_serial_ctrl`

## Requirements
- R1: While cs_n is high, sdo is high-impedance.
- R2: The status byte is {cmp_res[2], cmp_res[1], cmp_res[0], lowbat, 4'b0000}, bit 7 first, and is captured as cs_n falls. sdo shows status bit 7 from the start of the transfer. Each later bit appears on the sdo line after the falling scl edge that follows a rising scl edge.
- R3: sdi is sampled on rising scl edges, and the first bit received is bit 7 of the command byte.
- R4: A command takes effect only if exactly 8 rising scl edges were seen between the fall and the rise of cs_n. Transfers of any other length change no register.
- R5: For a command with bit 7 = 0, address bits 6:5 select the target. Address 00 loads {dr2, dr1, reg3, reg2, run} from bits 4..0. Address 01 loads {auto-backup, backup, 15 mA, 1 mA} from bits 3..0. Address 10 loads vout_code from bits 4:0.
- R6: A command with bit 7 = 1 loads dac_code from bits 6:0. cmp_en is high exactly when dac_code is non-zero.
- R7: After reset, vout_code = 5'b01100 and every other register bit is 0. The block therefore starts in coast mode with drivers, regulators 2 and 3, charger, backup and comparators off.
- R8: dr2_en = dr2 register bit AND dr2_gate. dr1_en, reg2_en and reg3_en follow their register bits.
- R9: Backup is active when the backup bit is set, or when the auto-backup bit and lowbat are both high. Active backup drives backup_en high and forces conv_en, run_mode, chg_hi and chg_lo low. Otherwise conv_en = 1 and run_mode follows the run bit.
- R10: chg_hi follows the 15 mA bit. chg_lo is high only when the 1 mA bit is set and the 15 mA bit is clear.
- R11: While rst_det is high, every register is forced to its R7 value on each clock.
- R12: Commands to address 11, and bit 4 of a command to address 01, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| scl | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out, high-impedance while deselected |
| cmp_res | input | 3 | Comparator results, channel 2 down to channel 0 |
| lowbat | input | 1 | Low-battery flag |
| dr2_gate | input | 1 | External gate for driver 2 |
| rst_det | input | 1 | Reset-detector input, active high |
| conv_en | output | 1 | Converter enable |
| run_mode | output | 1 | Converter in run (PWM) mode |
| reg2_en | output | 1 | Regulator 2 enable |
| reg3_en | output | 1 | Regulator 3 enable |
| dr1_en | output | 1 | Driver 1 enable |
| dr2_en | output | 1 | Driver 2 enable |
| chg_hi | output | 1 | High charge current select |
| chg_lo | output | 1 | Low charge current select |
| backup_en | output | 1 | Backup regulator enable |
| cmp_en | output | 1 | Comparator and threshold DAC enable |
| vout_code | output | 5 | Output-voltage code |
| dac_code | output | 7 | Comparator threshold code |

## Verification
The bench builds the block with its defaults: two synchronizer stages and a power-on voltage code of 01100. With these values a serial half-period of eight system clocks covers the full capture latency, so every one of the 256 command bytes can be sent in turn. That sweep reaches every address, every payload, all 128 threshold codes and every combination of the backup, auto-backup and charge bits. Each byte goes out with its own status pattern and gate levels, and the combinational outputs are then checked again with lowbat and dr2_gate inverted. Short and long transfers and a reset-detector pulse show that registers hold or return to their power-on values.

// File: rtl/pm_serial_ctrl.sv
module pm_serial_ctrl #(
  parameter int          SYNC_STAGES = 2,
  parameter logic [4:0]  VOUT_POR    = 5'b01100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       scl,
  input  logic       sdi,
  output logic       sdo,
  input  logic [2:0] cmp_res,
  input  logic       lowbat,
  input  logic       dr2_gate,
  input  logic       rst_det,
  output logic       conv_en,
  output logic       run_mode,
  output logic       reg2_en,
  output logic       reg3_en,
  output logic       dr1_en,
  output logic       dr2_en,
  output logic       chg_hi,
  output logic       chg_lo,
  output logic       backup_en,
  output logic       cmp_en,
  output logic [4:0] vout_code,
  output logic [6:0] dac_code
);
  localparam int LAST = SYNC_STAGES - 1;
  localparam logic [3:0] FULL = 4'd8;
  localparam logic [3:0] OVER = 4'd9;

  logic [LAST:0] cs_sy, scl_sy, sdi_sy;
  logic          cs_p, scl_p;
  logic          cs_d, scl_d, sdi_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sy  <= '1;
      scl_sy <= '0;
      sdi_sy <= '0;
      cs_p   <= 1'b1;
      scl_p  <= 1'b0;
    end else begin
      cs_sy  <= {cs_sy[LAST-1:0], cs_n};
      scl_sy <= {scl_sy[LAST-1:0], scl};
      sdi_sy <= {sdi_sy[LAST-1:0], sdi};
      cs_p   <= cs_d;
      scl_p  <= scl_d;
    end

  assign cs_d  = cs_sy[LAST];
  assign scl_d = scl_sy[LAST];
  assign sdi_d = sdi_sy[LAST];

  wire cs_rise  = ~cs_p & cs_d;
  wire scl_rise = ~cs_d & ~scl_p & scl_d;
  wire scl_fall = ~cs_d & scl_p & ~scl_d;

  logic [3:0] cnt;
  logic [7:0] rx, tx;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0;
      rx  <= '0;
      tx  <= '0;
    end else begin
      if (cs_d) begin
        cnt <= '0;
        tx  <= {cmp_res, lowbat, 4'b0000};
      end else begin
        if (scl_rise) begin
          rx <= {rx[6:0], sdi_d};
          if (cnt != OVER) cnt <= cnt + 4'd1;
        end
        if (scl_fall && cnt != 4'd0) tx <= {tx[6:0], 1'b0};
      end
    end

  assign sdo = cs_d ? 1'bz : tx[7];

  logic [4:0] r_ctl;
  logic [3:0] r_sup;
  logic [4:0] r_vout;
  logic [6:0] r_dac;

  wire commit = cs_rise && (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      r_ctl  <= '0;
      r_sup  <= '0;
      r_vout <= VOUT_POR;
      r_dac  <= '0;
    end else if (rst_det) begin
      r_ctl  <= '0;
      r_sup  <= '0;
      r_vout <= VOUT_POR;
      r_dac  <= '0;
    end else if (commit) begin
      if (rx[7]) r_dac <= rx[6:0];
      else begin
        case (rx[6:5])
          2'b00:   r_ctl  <= rx[4:0];
          2'b01:   r_sup  <= rx[3:0];
          2'b10:   r_vout <= rx[4:0];
          default: ;
        endcase
      end
    end

  wire bk_act = r_sup[2] | (r_sup[3] & lowbat);

  assign backup_en = bk_act;
  assign conv_en   = ~bk_act;
  assign run_mode  = r_ctl[0] & ~bk_act;
  assign reg2_en   = r_ctl[1];
  assign reg3_en   = r_ctl[2];
  assign dr1_en    = r_ctl[3];
  assign dr2_en    = r_ctl[4] & dr2_gate;
  assign chg_hi    = r_sup[1] & ~bk_act;
  assign chg_lo    = r_sup[0] & ~r_sup[1] & ~bk_act;
  assign cmp_en    = |r_dac;
  assign vout_code = r_vout;
  assign dac_code  = r_dac;

  a_r2_status_capture: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_d) |-> tx == $past({cmp_res, lowbat, 4'b0000}));

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= OVER);

  a_r4_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit && !rst_det |=> $stable({r_ctl, r_sup, r_vout, r_dac}));

  a_r8_dr2_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    dr2_en |-> dr2_gate);

  a_r9_backup_blocks_power: assert property (@(posedge clk) disable iff (!rst_n)
    backup_en |-> !conv_en && !run_mode && !chg_hi && !chg_lo);

  a_r10_single_charge: assert property (@(posedge clk) disable iff (!rst_n)
    !(chg_hi && chg_lo));

  a_r11_detector_reset: assert property (@(posedge clk) disable iff (!rst_n)
    rst_det |=> vout_code == VOUT_POR && dac_code == 7'd0 && !reg2_en && !reg3_en
               && !dr1_en && !run_mode && !backup_en && !chg_hi && !chg_lo);
endmodule

// File: tb/sim_pm_serial_ctrl.sv
module sim_pm_serial_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, scl = 1'b0, sdi = 1'b0;
  logic [2:0] cmp_res = '0;
  logic lowbat = 1'b0, dr2_gate = 1'b0, rst_det = 1'b0;
  wire  sdo;
  logic conv_en, run_mode, reg2_en, reg3_en, dr1_en, dr2_en;
  logic chg_hi, chg_lo, backup_en, cmp_en;
  logic [4:0] vout_code;
  logic [6:0] dac_code;

  int checks = 0, fails = 0;

  logic [4:0] m_ctl;
  logic [3:0] m_sup;
  logic [4:0] m_vout;
  logic [6:0] m_dac;

  pm_serial_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .scl(scl), .sdi(sdi), .sdo(sdo),
    .cmp_res(cmp_res), .lowbat(lowbat), .dr2_gate(dr2_gate), .rst_det(rst_det),
    .conv_en(conv_en), .run_mode(run_mode), .reg2_en(reg2_en), .reg3_en(reg3_en),
    .dr1_en(dr1_en), .dr2_en(dr2_en), .chg_hi(chg_hi), .chg_lo(chg_lo),
    .backup_en(backup_en), .cmp_en(cmp_en), .vout_code(vout_code), .dac_code(dac_code));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_por();
    m_ctl = '0; m_sup = '0; m_vout = 5'b01100; m_dac = '0;
  endtask

  task automatic check_outputs(input string tag);
    logic bk;
    bk = m_sup[2] | (m_sup[3] & lowbat);
    chk({tag, " vout"}, vout_code, m_vout);
    chk({tag, " dac"},  dac_code,  m_dac);
    chk("R6 cmp_en", cmp_en, m_dac != 0);
    chk("R8 reg2/reg3/dr1", {reg2_en, reg3_en, dr1_en}, {m_ctl[1], m_ctl[2], m_ctl[3]});
    chk("R8 dr2_en", dr2_en, m_ctl[4] & dr2_gate);
    chk("R9 backup_en", backup_en, bk);
    chk("R9 conv_en/run_mode", {conv_en, run_mode}, {~bk, m_ctl[0] & ~bk});
    chk("R10 chg_hi/chg_lo", {chg_hi, chg_lo}, {m_sup[1] & ~bk, m_sup[0] & ~m_sup[1] & ~bk});
  endtask

  task automatic xfer(input int n, input logic [15:0] data, output logic [7:0] rd);
    rd = '0;
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      sdi = data[n-1-i];
      repeat (8) @(negedge clk);
      if (i < 8) rd[7-i] = sdo;
      scl = 1'b1;
      repeat (8) @(negedge clk);
      scl = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic commit_model(input logic [7:0] d);
    if (d[7]) m_dac = d[6:0];
    else case (d[6:5])
      2'b00: m_ctl = d[4:0];
      2'b01: m_sup = d[3:0];
      2'b10: m_vout = d[4:0];
      default: ;
    endcase
  endtask

  initial begin
    logic [7:0] rd;
    model_por();
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check_outputs("R7 reset");
    chk("R1 sdo idle", sdo === 1'bz, 1);

    for (int b = 0; b < 256; b++) begin
      logic [7:0] d;
      logic [7:0] st;
      string tag;
      d = b[7:0];
      cmp_res  = d[6:4] ^ {d[0], d[7], d[3]};
      lowbat   = ^d[2:0];
      dr2_gate = d[1] ^ d[4];
      st = {cmp_res, lowbat, 4'b0000};
      repeat (4) @(negedge clk);
      xfer(8, {8'h00, d}, rd);
      chk("R2 status byte", rd, st);
      commit_model(d);
      if (d[7]) tag = "R6";
      else if (d[6:5] == 2'b11 || (d[6:5] == 2'b01 && d[4])) tag = "R12";
      else tag = "R3 R5";
      check_outputs(tag);
      chk("R1 sdo after transfer", sdo === 1'bz, 1);
      lowbat = ~lowbat;
      dr2_gate = ~dr2_gate;
      @(negedge clk);
      check_outputs("R9 toggled inputs");
    end

    xfer(8, 16'h0021, rd); commit_model(8'h21);
    xfer(8, 16'h0045, rd); commit_model(8'h45);
    xfer(7, 16'h0051, rd);
    check_outputs("R4 seven bits");
    xfer(9, 16'h00A3, rd);
    check_outputs("R4 nine bits");
    xfer(0, 16'h0000, rd);
    check_outputs("R4 empty select");

    @(negedge clk) rst_det = 1'b1;
    @(negedge clk) rst_det = 1'b0;
    @(negedge clk);
    model_por();
    check_outputs("R11 detector");
    xfer(8, 16'h0066, rd);
    check_outputs("R12 address 11 after reset");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule